// File: doc/BRIEF.md
# Trigger Acceptance and Event Numbering Unit

This unit sits between the raw trigger sources of a data acquisition system and the readout subsystems. Each clock cycle it looks at a vector of trigger inputs. Any input whose type is disabled by software is dropped. Each enabled type passes through its own prescaler, so only every Nth occurrence of that type qualifies. When the unit is idle and no masked-in subsystem reports busy, the lowest-numbered qualifying type wins. This is the first-level decision.

Each type can be marked as needing a second-level verdict. For such a type the unit parks the candidate and waits for an external accept or reject pulse. Once an event is accepted, the unit issues a one-cycle strobe. The strobe carries the current event number and a code that names the winning type, so every subsystem tags the data with the same number. The unit then blocks all further triggers until every worker selected by software has acknowledged the event. Software sets the masks and prescale factors through a small word-wide register port, and can read and clear the event counter through the same port.

Top module: `trig_mgr_top`

## Requirements
- R1: After reset there is no strobe and hold is low. The event counter (address 4) reads 0, the type-enable mask (address 0) reads 0, the second-level mask (address 1) reads 0, and the busy mask (address 2) and worker mask (address 3) read all ones. Every prescale register (address 8+i) reads 0. Unmapped addresses read 0.
- R2: A trigger input whose bit in the type-enable mask (address 0, bit i for type i) is 0 has no effect: it does not issue an event and does not advance that type's prescale count.
- R3: While the unit is idle and any busy input whose bit is set in the busy mask (address 2, bit j for input j) is high, no trigger is accepted and no prescale count changes. Busy inputs whose mask bit is clear have no effect.
- R4: The prescale register of type i (address 8+i, low PRESC_W bits) holds a value N. With N of 0 or 1, every counted occurrence qualifies. With N of 2 or more, the Nth, 2Nth and later counted occurrences qualify. A counted occurrence is a cycle in which the unit is idle and not busy and the input is high and enabled. Writing the prescale register restarts that type's count.
- R5: On issue, ev_strobe_o is high for exactly one cycle. ev_num_o holds the number of events issued since reset or the last counter clear, modulo 2^EVNUM_W, so the first event is number 0. Between strobes ev_num_o keeps its last value.
- R6: ev_code_o is the index of the winning type, which is the lowest-numbered qualifying type. Every qualifying type in that cycle reloads its prescale count, including those that lose.
- R7: After a strobe, hold_o stays high until each worker with its bit set in the worker mask (address 3) has pulsed ack_in at least once. Acks count from the strobe cycle onward. Triggers seen while hold_o is high are neither accepted nor counted. With a worker mask of 0, hold_o falls one cycle after the strobe.
- R8: When the winning type has its bit set in the second-level mask (address 1), no strobe is issued at once and hold_o goes high. A later l1_accept issues the strobe in the next cycle. An l1_reject returns the unit to idle without using an event number. If both arrive in the same cycle, accept wins.
- R9: Writing any value to address 4 clears the event counter to 0. A clear in the same cycle as an issue takes priority: the strobe still shows the old number, and the counter reads 0 afterwards.
- R10: A trigger that qualifies in cycle k, or an l1_accept in cycle k, makes ev_strobe_o high in cycle k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | N_TYPES | Raw trigger occurrences, one bit per type, each high cycle counts once |
| busy_in | input | N_SUBSYS | Busy flags from the readout subsystems |
| l1_accept | input | 1 | Second-level accept verdict for the parked candidate |
| l1_reject | input | 1 | Second-level reject verdict for the parked candidate |
| ack_in | input | N_WORKERS | Per-worker acknowledge pulses for the current event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ev_strobe_o | output | 1 | One-cycle event issue strobe |
| ev_num_o | output | EVNUM_W | Event number sent with the strobe |
| ev_code_o | output | max(1,clog2(N_TYPES)) | Index of the type that fired |
| hold_o | output | 1 | High while a candidate waits for its verdict or for acknowledges |

## Verification
The bench builds the unit with four trigger types, two busy inputs, three workers, a 3-bit prescale field and a 4-bit event number. The narrow event number lets the counter wrap within a few dozen events, so the modulo behaviour is checked directly. The 3-bit prescale field lets random writes reach the largest factor, 7. Three workers give a mask with one slot that can be switched off, so an ack from an unused worker can be shown to have no effect on the release.

// File: rtl/trig_mgr_pkg.sv
`timescale 1ns/1ps
package trig_mgr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_L1_WAIT  = 2'd1,
        ST_ACK_WAIT = 2'd2
    } tm_state_e;

    localparam int REG_AW = 4;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] A_TYPE_EN   = 4'd0;
    localparam logic [REG_AW-1:0] A_L1_NEED   = 4'd1;
    localparam logic [REG_AW-1:0] A_BUSY_MSK  = 4'd2;
    localparam logic [REG_AW-1:0] A_WORK_MSK  = 4'd3;
    localparam logic [REG_AW-1:0] A_EVCOUNT   = 4'd4;
    localparam int                PRESC_BASE  = 8;

endpackage

// File: rtl/trig_cfg_regs.sv
`timescale 1ns/1ps
module trig_cfg_regs
    import trig_mgr_pkg::*;
#(
    parameter int N_TYPES   = 4,
    parameter int N_SUBSYS  = 2,
    parameter int N_WORKERS = 4,
    parameter int PRESC_W   = 8,
    parameter int EVNUM_W   = 24
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [REG_AW-1:0]                 addr,
    input  logic [REG_DW-1:0]                 wdata,
    output logic [REG_DW-1:0]                 rdata,
    input  logic [EVNUM_W-1:0]                evcnt,
    output logic [N_TYPES-1:0]                type_en_o,
    output logic [N_TYPES-1:0]                l1_need_o,
    output logic [N_SUBSYS-1:0]               busy_msk_o,
    output logic [N_WORKERS-1:0]              work_msk_o,
    output logic [N_TYPES-1:0][PRESC_W-1:0]   presc_o,
    output logic [N_TYPES-1:0]                presc_wr_o,
    output logic                              evclr_o
);

    typedef struct packed {
        logic [N_TYPES-1:0]              type_en;
        logic [N_TYPES-1:0]              l1_need;
        logic [N_SUBSYS-1:0]             busy_msk;
        logic [N_WORKERS-1:0]            work_msk;
        logic [N_TYPES-1:0][PRESC_W-1:0] presc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata_bits;

    assign unused_wdata_bits = ^wdata;

    always_comb begin
        cfg_d      = cfg_q;
        presc_wr_o = '0;
        evclr_o    = 1'b0;
        if (we) begin
            if (addr == A_TYPE_EN)  cfg_d.type_en  = wdata[N_TYPES-1:0];
            if (addr == A_L1_NEED)  cfg_d.l1_need  = wdata[N_TYPES-1:0];
            if (addr == A_BUSY_MSK) cfg_d.busy_msk = wdata[N_SUBSYS-1:0];
            if (addr == A_WORK_MSK) cfg_d.work_msk = wdata[N_WORKERS-1:0];
            if (addr == A_EVCOUNT)  evclr_o        = 1'b1;
            for (int i = 0; i < N_TYPES; i++) begin
                if (addr == REG_AW'(PRESC_BASE + i)) begin
                    cfg_d.presc[i] = wdata[PRESC_W-1:0];
                    presc_wr_o[i]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.type_en  <= '0;
            cfg_q.l1_need  <= '0;
            cfg_q.busy_msk <= '1;
            cfg_q.work_msk <= '1;
            cfg_q.presc    <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_TYPE_EN)  rdata = REG_DW'(cfg_q.type_en);
        if (addr == A_L1_NEED)  rdata = REG_DW'(cfg_q.l1_need);
        if (addr == A_BUSY_MSK) rdata = REG_DW'(cfg_q.busy_msk);
        if (addr == A_WORK_MSK) rdata = REG_DW'(cfg_q.work_msk);
        if (addr == A_EVCOUNT)  rdata = REG_DW'(evcnt);
        for (int i = 0; i < N_TYPES; i++) begin
            if (addr == REG_AW'(PRESC_BASE + i)) rdata = REG_DW'(cfg_q.presc[i]);
        end
    end

    assign type_en_o  = cfg_q.type_en;
    assign l1_need_o  = cfg_q.l1_need;
    assign busy_msk_o = cfg_q.busy_msk;
    assign work_msk_o = cfg_q.work_msk;
    assign presc_o    = cfg_q.presc;

    AST_CLEAR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        evclr_o |-> (we && addr == A_EVCOUNT)); // R9

endmodule

// File: rtl/trig_presc_lane.sv
`timescale 1ns/1ps
module trig_presc_lane #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               occ,
    input  logic               clr,
    input  logic [PRESC_W-1:0] presc,
    output logic               qual_o
);

    typedef struct packed {
        logic [PRESC_W-1:0] cnt;
    } lane_t;

    lane_t ln_d, ln_q;
    logic  reached;

    assign reached = (presc <= PRESC_W'(1)) ||
                     (({1'b0, ln_q.cnt} + (PRESC_W+1)'(1)) >= {1'b0, presc});
    assign qual_o  = occ && reached;

    always_comb begin
        ln_d = ln_q;
        if (occ) begin
            if (reached) ln_d.cnt = '0;
            else         ln_d.cnt = ln_q.cnt + PRESC_W'(1);
        end
        if (clr) ln_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    AST_LANE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |=> (ln_q.cnt == '0)); // R4
    AST_LANE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!occ && !clr) |=> $stable(ln_q.cnt)); // R3

endmodule

// File: rtl/trig_prio_pick.sv
`timescale 1ns/1ps
module trig_prio_pick #(
    parameter int N_REQ = 4,
    localparam int IW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] req,
    output logic             valid_o,
    output logic [IW-1:0]    idx_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/trig_ack_collect.sv
`timescale 1ns/1ps
module trig_ack_collect #(
    parameter int N_WORKERS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 active,
    input  logic [N_WORKERS-1:0] ack,
    input  logic [N_WORKERS-1:0] mask,
    output logic                 done_o
);

    typedef struct packed {
        logic [N_WORKERS-1:0] seen;
    } ack_t;

    ack_t ak_d, ak_q;

    assign done_o = active && (&(ak_q.seen | ack | ~mask));

    always_comb begin
        ak_d = ak_q;
        if (start)       ak_d.seen = '0;
        else if (active) ak_d.seen = ak_q.seen | ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ak_q <= '0;
        else        ak_q <= ak_d;
    end

    AST_SEEN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (ak_q.seen == '0)); // R7

endmodule

// File: rtl/trig_mgr_top.sv
`timescale 1ns/1ps
module trig_mgr_top
    import trig_mgr_pkg::*;
#(
    parameter int N_TYPES   = 4,
    parameter int N_SUBSYS  = 2,
    parameter int N_WORKERS = 4,
    parameter int PRESC_W   = 8,
    parameter int EVNUM_W   = 24,
    localparam int CODE_W   = (N_TYPES > 1) ? $clog2(N_TYPES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_TYPES-1:0]   trig_in,
    input  logic [N_SUBSYS-1:0]  busy_in,
    input  logic                 l1_accept,
    input  logic                 l1_reject,
    input  logic [N_WORKERS-1:0] ack_in,
    input  logic                 reg_we,
    input  logic [3:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 ev_strobe_o,
    output logic [EVNUM_W-1:0]   ev_num_o,
    output logic [CODE_W-1:0]    ev_code_o,
    output logic                 hold_o
);

    typedef struct packed {
        tm_state_e           state;
        logic [CODE_W-1:0]   pend;
        logic                strobe;
        logic [EVNUM_W-1:0]  num;
        logic [CODE_W-1:0]   code;
        logic [EVNUM_W-1:0]  evcnt;
    } tm_t;

    tm_t tm_d, tm_q;

    logic [N_TYPES-1:0]              type_en, l1_need, presc_wr, occ, qual;
    logic [N_SUBSYS-1:0]             busy_msk;
    logic [N_WORKERS-1:0]            work_msk;
    logic [N_TYPES-1:0][PRESC_W-1:0] presc;
    logic                            evclr, busy_act, open_win;
    logic                            pick_valid, ack_done, issue;
    logic [CODE_W-1:0]               pick_idx, issue_code;

    trig_cfg_regs #(
        .N_TYPES   (N_TYPES),
        .N_SUBSYS  (N_SUBSYS),
        .N_WORKERS (N_WORKERS),
        .PRESC_W   (PRESC_W),
        .EVNUM_W   (EVNUM_W)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .evcnt      (tm_q.evcnt),
        .type_en_o  (type_en),
        .l1_need_o  (l1_need),
        .busy_msk_o (busy_msk),
        .work_msk_o (work_msk),
        .presc_o    (presc),
        .presc_wr_o (presc_wr),
        .evclr_o    (evclr)
    );

    assign busy_act = |(busy_in & busy_msk);
    assign open_win = (tm_q.state == ST_IDLE) && !busy_act;
    assign occ      = trig_in & type_en & {N_TYPES{open_win}};

    for (genvar g = 0; g < N_TYPES; g++) begin : g_lane
        trig_presc_lane #(.PRESC_W(PRESC_W)) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .occ    (occ[g]),
            .clr    (presc_wr[g]),
            .presc  (presc[g]),
            .qual_o (qual[g])
        );
    end

    trig_prio_pick #(.N_REQ(N_TYPES)) pick_i (
        .req     (qual),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    trig_ack_collect #(.N_WORKERS(N_WORKERS)) ack_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (issue),
        .active (tm_q.state == ST_ACK_WAIT),
        .ack    (ack_in),
        .mask   (work_msk),
        .done_o (ack_done)
    );

    always_comb begin
        tm_d        = tm_q;
        tm_d.strobe = 1'b0;
        issue       = 1'b0;
        issue_code  = pick_idx;
        case (tm_q.state)
            ST_IDLE: begin
                if (pick_valid) begin
                    if (l1_need[pick_idx]) begin
                        tm_d.state = ST_L1_WAIT;
                        tm_d.pend  = pick_idx;
                    end else begin
                        issue = 1'b1;
                    end
                end
            end
            ST_L1_WAIT: begin
                if (l1_accept) begin
                    issue      = 1'b1;
                    issue_code = tm_q.pend;
                end else if (l1_reject) begin
                    tm_d.state = ST_IDLE;
                end
            end
            ST_ACK_WAIT: begin
                if (ack_done) tm_d.state = ST_IDLE;
            end
            default: tm_d.state = ST_IDLE;
        endcase
        if (issue) begin
            tm_d.state  = ST_ACK_WAIT;
            tm_d.strobe = 1'b1;
            tm_d.num    = tm_q.evcnt;
            tm_d.code   = issue_code;
            tm_d.evcnt  = tm_q.evcnt + EVNUM_W'(1);
        end
        if (evclr) tm_d.evcnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign ev_strobe_o = tm_q.strobe;
    assign ev_num_o    = tm_q.num;
    assign ev_code_o   = tm_q.code;
    assign hold_o      = (tm_q.state != ST_IDLE);

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_strobe_o |=> !ev_strobe_o); // R5
    AST_EVNUM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_strobe_o && !$past(evclr)) |-> (tm_q.evcnt == ev_num_o + EVNUM_W'(1))); // R5
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.state == ST_IDLE && busy_act) |=> (!ev_strobe_o && !hold_o)); // R3
    AST_HOLD_UNTIL_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.state == ST_ACK_WAIT && !ack_done) |=> hold_o); // R7
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (qual[pick_idx] &&
            ((qual & ((N_TYPES'(1) << pick_idx) - N_TYPES'(1))) == '0))); // R6
    AST_L1_GATES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.state == ST_L1_WAIT && !l1_accept) |=> !ev_strobe_o); // R8
    AST_STROBE_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_strobe_o |-> hold_o); // R10

endmodule

// File: tb/trig_mgr_top_tb_top.sv
`timescale 1ns/1ps
module trig_mgr_top_tb_top;

    localparam int NT = 4;
    localparam int NS = 2;
    localparam int NW = 3;
    localparam int PW = 3;
    localparam int EW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] trig_in = '0;
    logic [NS-1:0] busy_in = '0;
    logic          l1_accept = 1'b0, l1_reject = 1'b0;
    logic [NW-1:0] ack_in = '0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          ev_strobe_o, hold_o;
    logic [EW-1:0] ev_num_o;
    logic [1:0]    ev_code_o;

    always #4 clk = ~clk;

    trig_mgr_top #(
        .N_TYPES(NT), .N_SUBSYS(NS), .N_WORKERS(NW), .PRESC_W(PW), .EVNUM_W(EW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .busy_in(busy_in),
        .l1_accept(l1_accept), .l1_reject(l1_reject), .ack_in(ack_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ev_strobe_o(ev_strobe_o), .ev_num_o(ev_num_o),
        .ev_code_o(ev_code_o), .hold_o(hold_o)
    );

    int n_chk = 0;
    int n_err = 0;

    // stimulus for the next tick
    logic [NT-1:0] s_trig;
    logic [NS-1:0] s_busy;
    logic          s_l1a, s_l1r, s_we;
    logic [NW-1:0] s_ack;
    logic [3:0]    s_addr;
    logic [31:0]   s_wdata;

    // reference model state (values the outputs show after the coming edge)
    int            m_st, m_pend, m_code, m_num, m_ev;
    logic          m_strobe;
    logic [NT-1:0] m_en, m_l1;
    logic [NS-1:0] m_bm;
    logic [NW-1:0] m_wm, m_seen;
    int            m_presc [NT];
    int            m_cnt   [NT];
    logic [31:0]   m_rdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] r = '0;
        if (a == 4'd0) r = 32'(m_en);
        if (a == 4'd1) r = 32'(m_l1);
        if (a == 4'd2) r = 32'(m_bm);
        if (a == 4'd3) r = 32'(m_wm);
        if (a == 4'd4) r = 32'(m_ev);
        for (int i = 0; i < NT; i++) if (int'(a) == 8 + i) r = 32'(m_presc[i]);
        return r;
    endfunction

    task automatic model_reset();
        m_st = 0; m_pend = 0; m_code = 0; m_num = 0; m_ev = 0; m_strobe = 1'b0;
        m_en = '0; m_l1 = '0; m_bm = '1; m_wm = '1; m_seen = '0;
        for (int i = 0; i < NT; i++) begin m_presc[i] = 0; m_cnt[i] = 0; end
        m_rdata = model_read(4'd0);
    endtask

    task automatic model_step();
        logic bact;
        int   w, icode, nst, npend;
        logic issue;
        int   ncnt [NT];
        bact  = |(s_busy & m_bm);
        w     = -1;
        icode = 0;
        issue = 1'b0;
        nst   = m_st;
        npend = m_pend;
        for (int i = 0; i < NT; i++) ncnt[i] = m_cnt[i];
        if (m_st == 0) begin
            if (!bact) begin
                for (int i = 0; i < NT; i++) begin
                    if (s_trig[i] && m_en[i]) begin
                        if (m_presc[i] <= 1 || m_cnt[i] + 1 >= m_presc[i]) begin
                            ncnt[i] = 0;
                            if (w < 0) w = i;
                        end else begin
                            ncnt[i] = m_cnt[i] + 1;
                        end
                    end
                end
            end
            if (w >= 0) begin
                if (m_l1[w]) begin nst = 1; npend = w; end
                else begin issue = 1'b1; icode = w; end
            end
        end else if (m_st == 1) begin
            if (s_l1a) begin issue = 1'b1; icode = m_pend; end
            else if (s_l1r) nst = 0;
        end else begin
            if (&(m_seen | s_ack | ~m_wm)) nst = 0;
            m_seen = m_seen | s_ack;
        end
        m_strobe = 1'b0;
        if (issue) begin
            m_strobe = 1'b1;
            m_num    = m_ev;
            m_code   = icode;
            m_ev     = (m_ev + 1) % (1 << EW);
            nst      = 2;
            m_seen   = '0;
        end
        m_st = nst;
        m_pend = npend;
        for (int i = 0; i < NT; i++) m_cnt[i] = ncnt[i];
        if (s_we) begin
            if (s_addr == 4'd0) m_en = s_wdata[NT-1:0];
            if (s_addr == 4'd1) m_l1 = s_wdata[NT-1:0];
            if (s_addr == 4'd2) m_bm = s_wdata[NS-1:0];
            if (s_addr == 4'd3) m_wm = s_wdata[NW-1:0];
            if (s_addr == 4'd4) m_ev = 0;
            for (int i = 0; i < NT; i++) begin
                if (int'(s_addr) == 8 + i) begin
                    m_presc[i] = int'(s_wdata[PW-1:0]);
                    m_cnt[i]   = 0;
                end
            end
        end
        m_rdata = model_read(s_addr);
    endtask

    task automatic clear_stim();
        s_trig = '0; s_busy = '0; s_l1a = 1'b0; s_l1r = 1'b0; s_ack = '0;
        s_we = 1'b0; s_addr = '0; s_wdata = '0;
    endtask

    // compare at the falling edge, then drive and advance the model
    task automatic tick();
        @(negedge clk);
        chk("R10 strobe", 32'(ev_strobe_o), 32'(m_strobe));
        chk("R5 number", 32'(ev_num_o), 32'(m_num));
        chk("R6 code", 32'(ev_code_o), 32'(m_code));
        chk("R7 hold", 32'(hold_o), 32'(m_st != 0));
        chk("R9 readback", reg_rdata, m_rdata);
        trig_in = s_trig; busy_in = s_busy; l1_accept = s_l1a; l1_reject = s_l1r;
        ack_in = s_ack; reg_we = s_we; reg_addr = s_addr; reg_wdata = s_wdata;
        model_step();
        clear_stim();
    endtask

    task automatic post();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        s_we = 1'b1; s_addr = a; s_wdata = d;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int expn;
        void'($urandom(32'h5EED_0C1A));
        clear_stim();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        s_addr = 4'd3; tick(); post();
        chk("R1 worker mask reset", reg_rdata, 32'h7);
        chk("R1 strobe reset", 32'(ev_strobe_o), 32'h0);
        chk("R1 hold reset", 32'(hold_o), 32'h0);
        s_addr = 4'd2; tick(); post();
        chk("R1 busy mask reset", reg_rdata, 32'h3);
        s_addr = 4'd4; tick(); post();
        chk("R1 event counter reset", reg_rdata, 32'h0);
        s_addr = 4'd9; tick(); post();
        chk("R1 prescale reset", reg_rdata, 32'h0);

        wr(4'd0, 32'hF); wr(4'd2, 32'h1); wr(4'd3, 32'h3);

        // R10/R6: two types at once, lowest wins
        s_trig = 4'b0110; tick(); post();
        chk("R10 strobe next cycle", 32'(ev_strobe_o), 32'h1);
        chk("R5 first number", 32'(ev_num_o), 32'h0);
        chk("R6 lowest type", 32'(ev_code_o), 32'h1);
        chk("R7 hold after issue", 32'(hold_o), 32'h1);
        s_ack = 3'b100; tick(); post();
        chk("R7 unused worker ack", 32'(hold_o), 32'h1);
        s_ack = 3'b001; s_trig = 4'hF; tick(); post();
        chk("R7 partial ack", 32'(hold_o), 32'h1);
        chk("R7 trigger during hold", 32'(ev_strobe_o), 32'h0);
        s_ack = 3'b010; tick(); post();
        chk("R7 release", 32'(hold_o), 32'h0);

        // R3: masked and unmasked busy
        s_busy = 2'b01; s_trig = 4'b0001; tick(); post();
        chk("R3 masked busy blocks", 32'(ev_strobe_o), 32'h0);
        s_busy = 2'b10; s_trig = 4'b0001; tick(); post();
        chk("R3 unmasked busy ignored", 32'(ev_strobe_o), 32'h1);
        chk("R5 second number", 32'(ev_num_o), 32'h1);
        wr(4'd3, 32'h0); tick(); post();
        chk("R7 empty worker mask releases", 32'(hold_o), 32'h0);

        // R4: prescale of 3 on type 3
        wr(4'd0, 32'h8); wr(4'd11, 32'h3);
        for (int k = 1; k <= 6; k++) begin
            s_trig = 4'b1000; tick(); post();
            chk("R4 every third", 32'(ev_strobe_o), 32'((k % 3) == 0));
            tick();
        end

        // R2: disabled types
        wr(4'd0, 32'h1);
        s_trig = 4'b1110; tick(); post();
        chk("R2 disabled ignored", 32'(ev_strobe_o), 32'h0);
        s_trig = 4'b1111; tick(); post();
        chk("R2 enabled fires", 32'(ev_strobe_o), 32'h1);
        chk("R6 code of only enabled", 32'(ev_code_o), 32'h0);
        tick();
        wr(4'd0, 32'hC); wr(4'd11, 32'h0);
        s_trig = 4'b1110; tick(); post();
        chk("R6 lowest enabled", 32'(ev_code_o), 32'h2);
        tick();

        // R8: second-level verdict
        wr(4'd0, 32'hF); wr(4'd1, 32'h1);
        s_trig = 4'b0001; tick(); post();
        chk("R8 parked hold", 32'(hold_o), 32'h1);
        chk("R8 no strobe yet", 32'(ev_strobe_o), 32'h0);
        s_l1r = 1'b1; tick(); post();
        chk("R8 reject to idle", 32'(hold_o), 32'h0);
        chk("R8 reject no strobe", 32'(ev_strobe_o), 32'h0);
        s_trig = 4'b0001; tick();
        s_l1a = 1'b1; s_l1r = 1'b1; tick(); post();
        chk("R8 accept wins", 32'(ev_strobe_o), 32'h1);
        tick();

        // R9: counter clear and priority
        wr(4'd4, 32'h0);
        s_addr = 4'd4; tick(); post();
        chk("R9 cleared", reg_rdata, 32'h0);
        wr(4'd1, 32'h0);
        s_trig = 4'b0001; tick(); post();
        chk("R9 number after clear", 32'(ev_num_o), 32'h0);
        tick();
        s_trig = 4'b0001; s_we = 1'b1; s_addr = 4'd4; tick(); post();
        chk("R9 strobe keeps old number", 32'(ev_num_o), 32'h1);
        s_addr = 4'd4; tick(); post();
        chk("R9 clear beats increment", reg_rdata, 32'h0);

        // R5: wrap of the narrow counter
        expn = 0;
        for (int j = 0; j < 20; j++) begin
            s_trig = 4'b0001; tick(); post();
            chk("R5 wrap sequence", 32'(ev_num_o), 32'(expn % (1 << EW)));
            expn++;
            tick();
        end

        // constrained random phase, checked every cycle against the model
        for (int c = 0; c < 4000; c++) begin
            s_trig = 4'($urandom) & 4'($urandom);
            s_busy = (($urandom % 100) < 15) ? 2'($urandom) : 2'b00;
            s_ack  = 3'($urandom) & 3'($urandom);
            s_l1a  = (($urandom % 100) < 12);
            s_l1r  = (($urandom % 100) < 8);
            if (($urandom % 100) < 6) begin
                s_we    = 1'b1;
                case ($urandom % 9)
                    0: s_addr = 4'd0;
                    1: s_addr = 4'd1;
                    2: s_addr = 4'd2;
                    3: s_addr = 4'd3;
                    4: s_addr = 4'd4;
                    default: s_addr = 4'(8 + ($urandom % NT));
                endcase
                s_wdata = $urandom;
            end else begin
                s_addr = 4'($urandom);
            end
            tick();
        end
        tick();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule